// File: doc/BRIEF.md
# EEPROM page write engine

This block is a synthesizable model of the write machinery inside one parallel EEPROM bank. It can serve as a device emulator or as a target for a memory controller under test. A fast system clock samples the chip-enable, write-enable, output-enable and protect pins, together with the address and data buses. Strobes are formed from those samples, and very short strobes are rejected as noise. Bytes that arrive within a load window are collected into a page buffer. When the strobes stop for long enough, the block enters an internal programming phase. After a programmable busy time, it writes only the loaded bytes into a small internal array.

While the page is being loaded or programmed, the block pulls its ready/busy line low. A read during this time returns a polling status built from the last loaded byte, not array data. Pulling the protect pin low blocks reads and writes. If it goes low during a load or a programming phase, the page is discarded. All time limits are counted in system clock cycles. With a 4 ns clock, the default noise limit of 5 samples corresponds to 20 ns. The busy times are scaled down so that simulations stay short.

Top module: `eep_page_engine`

## Requirements
- R1: A strobe is a run of samples with both `ce_n` and `we_n` low. The address is taken from the first sample of the run. The data is taken from the last sample before the strobe is released, so an address change after the first sample and a data change before the last sample follow these rules.
- R2: A strobe of `GLITCH_CYC` samples or fewer (default 5, that is 20 ns) is ignored: it does not pull the busy line low and it changes no byte. A strobe of `GLITCH_CYC`+1 samples or more is accepted.
- R3: The page is taken from `addr[8:7]` of the first accepted byte of a load, and `addr[6:0]` selects one of the 128 buffer bytes. The page bits of later bytes are ignored. When an offset is loaded twice, the later byte wins.
- R4: A strobe accepted more than `LOAD_WIN_CYC` cycles after the previous accepted byte is ignored. Programming starts once `IDLE_CYC` cycles pass with no accepted byte.
- R5: Programming writes only the offsets that were loaded. Every other byte in the page and in the array keeps its contents.
- R6: `rb_pull_low` is 0 after reset. It rises within 4 cycles of the release of the first accepted strobe and stays 1 until programming ends, about `IDLE_CYC`+`WRITE_CYC` cycles after the last accepted byte.
- R7: While `rb_pull_low` is 1, a read returns the complement of bit 7 of the last accepted byte on bit 7, and that byte's bits 6:0 on bits 6:0. Once programming completes, reads return array contents.
- R8: While `res_n` is low, `dout_en` is 0 and strobes are ignored. `res_n` low during loading or programming discards the page, releases `rb_pull_low`, and leaves the array unchanged.
- R9: Strobes that arrive during programming are ignored. They neither change the array nor extend the busy time.
- R10: `dout_en` is 1 only two cycles after `ce_n`=0, `oe_n`=0, `we_n`=1 and `res_n`=1 are sampled together, and `dout` is valid then. In every other case the data bus is undriven (`dout_en`=0), and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low model reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| res_n | input | 1 | Protect pin, low blocks all access |
| addr | input | ADDR_W | Byte address (page bits above offset bits) |
| din | input | 8 | Write data bus |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | Data bus drive enable (0 means high impedance) |
| rb_pull_low | output | 1 | Ready/busy drive: 1 pulls the line low, 0 leaves it released |

## Verification
Read data and `dout_en` are due two clock edges after the pins are applied. The bench applies pins at a falling edge and samples three falling edges later, so the sample lands in a settled half-cycle. An accepted strobe sets busy within about three edges of its release, so the bench checks busy four cycles after the release. The end of programming falls about `IDLE_CYC`+`WRITE_CYC` cycles after the last accepted byte. The bench keeps a cycle counter and checks that busy is still high 40 cycles before this nominal end. It then requires busy to drop within a bounded window, and it reads polling status at a fixed point inside the programming phase. Array contents are compared against a bench model only after busy has dropped.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_e;
endpackage

// File: rtl/eep_strobe_filter.sv
// Forms write strobes from sampled pins and rejects short pulses.
module eep_strobe_filter #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned GLITCH_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [7:0]        din_s,
  output logic              evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [7:0]        evt_data
);
  localparam int unsigned RUN_MAX = GLITCH_CYC + 1;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

  logic             prev_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic             evt_q, evt_d;
  logic [ADDR_W-1:0] addr_hold_q;
  logic [7:0]       data_hold_q;
  logic             rise, fall;

  always_comb begin
    rise  = stb & ~prev_q;
    fall  = ~stb & prev_q;
    run_d = '0;
    if (stb) begin
      run_d = (run_q == RUN_W'(RUN_MAX)) ? run_q : run_q + 1'b1;
    end
    evt_d = fall & (run_q > RUN_W'(GLITCH_CYC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      run_q       <= '0;
      evt_q       <= 1'b0;
      addr_hold_q <= '0;
      data_hold_q <= '0;
    end else begin
      prev_q <= stb;
      run_q  <= run_d;
      evt_q  <= evt_d;
      if (rise) addr_hold_q <= addr_s;
      if (stb)  data_hold_q <= din_s;
    end
  end

  assign evt      = evt_q;
  assign evt_addr = addr_hold_q;
  assign evt_data = data_hold_q;

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q); // R1
endmodule

// File: rtl/eep_write_ctrl.sv
// Load / program state machine with window, idle and busy timers.
module eep_write_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned LOAD_WIN_CYC = 300,
  parameter int unsigned IDLE_CYC     = 1000,
  parameter int unsigned WRITE_CYC    = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic res_ok,
  output logic acc,
  output logic first,
  output logic clear,
  output logic commit,
  output logic busy,
  output logic in_prog
);
  localparam int unsigned TMAX  = (IDLE_CYC > WRITE_CYC) ? IDLE_CYC : WRITE_CYC;
  localparam int unsigned TMR_W = $clog2(TMAX + 1);

  eep_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             in_win;

  always_comb begin
    in_win = tmr_q < TMR_W'(LOAD_WIN_CYC);
    acc    = evt & res_ok &
             ((state_q == ST_IDLE) | ((state_q == ST_LOAD) & in_win));
  end

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    clear   = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (acc) begin
          state_d = ST_LOAD;
          tmr_d   = '0;
        end
      end
      ST_LOAD: begin
        if (!res_ok) begin
          state_d = ST_IDLE;
          clear   = 1'b1;
        end else if (acc) begin
          tmr_d = '0;
        end else if (tmr_q == TMR_W'(IDLE_CYC - 1)) begin
          state_d = ST_PROG;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (!res_ok) begin
          state_d = ST_IDLE;
          clear   = 1'b1;
        end else if (tmr_q == TMR_W'(WRITE_CYC - 1)) begin
          state_d = ST_IDLE;
          commit  = 1'b1;
          clear   = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        clear   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign in_prog = (state_q == ST_PROG);
  assign first   = (state_q == ST_IDLE);

  AST_COMMIT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> res_ok); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy); // R6
endmodule

// File: rtl/eep_page_buf.sv
// Page buffer: byte storage, loaded flags, page number and last byte.
module eep_page_buf #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned OFS_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc,
  input  logic                    first,
  input  logic                    clear,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  output logic [ADDR_W-OFS_W-1:0] page,
  output logic [7:0]              last_byte,
  output logic [(1<<OFS_W)-1:0]   valid,
  output logic [(1<<OFS_W)*8-1:0] data_flat
);
  localparam int unsigned PAGE_BYTES = 1 << OFS_W;
  localparam int unsigned PAGE_W     = ADDR_W - OFS_W;

  logic [OFS_W-1:0]      ofs;
  logic [PAGE_BYTES-1:0] valid_q;
  logic [PAGE_W-1:0]     page_q;
  logic [7:0]            last_q;

  assign ofs = wr_addr[OFS_W-1:0];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (acc && (ofs == OFS_W'(g))) byte_q <= wr_data;
    end
    assign data_flat[g*8 +: 8] = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      page_q  <= '0;
      last_q  <= '0;
    end else begin
      if (clear)    valid_q      <= '0;
      else if (acc) valid_q[ofs] <= 1'b1;
      if (acc && first) page_q <= wr_addr[ADDR_W-1:OFS_W];
      if (acc)          last_q <= wr_data;
    end
  end

  assign valid     = valid_q;
  assign page      = page_q;
  assign last_byte = last_q;
endmodule

// File: rtl/eep_cell_array.sv
// Byte array; programming writes the loaded bytes of one page at once.
module eep_cell_array #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned OFS_W  = 7
) (
  input  logic                    clk,
  input  logic                    commit,
  input  logic [ADDR_W-OFS_W-1:0] page,
  input  logic [(1<<OFS_W)-1:0]   valid,
  input  logic [(1<<OFS_W)*8-1:0] data_flat,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data
);
  localparam int unsigned DEPTH      = 1 << ADDR_W;
  localparam int unsigned PAGE_BYTES = 1 << OFS_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (valid[i]) cells[{page, OFS_W'(i)}] <= data_flat[i*8 +: 8];
      end
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eep_page_engine.sv
// Top: pin sampling, read path with polling status, sub-block wiring.
module eep_page_engine #(
  parameter int unsigned ADDR_W       = 9,
  parameter int unsigned OFS_W        = 7,
  parameter int unsigned GLITCH_CYC   = 5,
  parameter int unsigned LOAD_WIN_CYC = 300,
  parameter int unsigned IDLE_CYC     = 1000,
  parameter int unsigned WRITE_CYC    = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              res_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              rb_pull_low
);
  localparam int unsigned PAGE_BYTES = 1 << OFS_W;
  localparam int unsigned PAGE_W     = ADDR_W - OFS_W;

  logic              ce_q, we_q, oe_q, res_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      res_q  <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      ce_q   <= ce_n;
      we_q   <= we_n;
      oe_q   <= oe_n;
      res_q  <= res_n;
      addr_q <= addr;
      din_q  <= din;
    end
  end

  logic              evt;
  logic [ADDR_W-1:0] evt_addr;
  logic [7:0]        evt_data;

  eep_strobe_filter #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC)) u_flt (
    .clk(clk), .rst_n(rst_n), .stb(~ce_q & ~we_q),
    .addr_s(addr_q), .din_s(din_q),
    .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  logic acc, first, clear, commit, busy, in_prog;

  eep_write_ctrl #(
    .LOAD_WIN_CYC(LOAD_WIN_CYC), .IDLE_CYC(IDLE_CYC), .WRITE_CYC(WRITE_CYC)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .res_ok(res_q),
    .acc(acc), .first(first), .clear(clear), .commit(commit),
    .busy(busy), .in_prog(in_prog)
  );

  logic [PAGE_W-1:0]       page;
  logic [7:0]              last_byte;
  logic [PAGE_BYTES-1:0]   valid;
  logic [PAGE_BYTES*8-1:0] data_flat;

  eep_page_buf #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .acc(acc), .first(first), .clear(clear),
    .wr_addr(evt_addr), .wr_data(evt_data),
    .page(page), .last_byte(last_byte), .valid(valid), .data_flat(data_flat)
  );

  logic [7:0] arr_rd;

  eep_cell_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_arr (
    .clk(clk), .commit(commit), .page(page), .valid(valid),
    .data_flat(data_flat), .rd_addr(addr_q), .rd_data(arr_rd)
  );

  logic       rd_sel;
  logic [7:0] rd_val;
  logic [7:0] dout_q;
  logic       dout_en_q;

  always_comb begin
    rd_sel = ~ce_q & ~oe_q & we_q & res_q;
    rd_val = busy ? {~last_byte[7], last_byte[6:0]} : arr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      dout_en_q <= 1'b0;
    end else begin
      dout_en_q <= rd_sel;
      if (rd_sel) dout_q <= rd_val;
    end
  end

  assign dout        = dout_q;
  assign dout_en     = dout_en_q;
  assign rb_pull_low = busy;

  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !res_q |=> !dout_en_q); // R8
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |=> !dout_en_q); // R10
  AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && !clear) |=> $stable(valid)); // R9
endmodule

// File: tb/eep_page_engine_tb.sv
module eep_page_engine_tb;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned GLITCH = 5;
  localparam int unsigned LWIN   = 300;
  localparam int unsigned IDLE   = 1000;
  localparam int unsigned WRT    = 2000;

  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, oe_n, res_n;
  logic [ADDR_W-1:0] addr;
  logic [7:0] din, dout;
  logic dout_en, rb_pull_low;

  always #2 clk = ~clk;

  eep_page_engine #(
    .ADDR_W(ADDR_W), .OFS_W(7), .GLITCH_CYC(GLITCH),
    .LOAD_WIN_CYC(LWIN), .IDLE_CYC(IDLE), .WRITE_CYC(WRT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .res_n(res_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .rb_pull_low(rb_pull_low)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] ref_mem [512];
  logic [7:0] pb_data [128];
  bit         pb_vld  [128];
  logic [1:0] pb_page;
  bit         pb_open;
  logic [7:0] pb_last;
  longint     t_last;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      summary();
      $finish;
    end
  end

  // Raw strobe held low for w samples; no model update.
  task automatic pulse(input logic [8:0] a, input logic [7:0] d, input int w);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (w) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Accepted byte: strobe plus model update.
  task automatic wr_byte(input logic [8:0] a, input logic [7:0] d, input int w);
    pulse(a, d, w);
    if (!pb_open) begin
      pb_open = 1'b1;
      pb_page = a[8:7];
    end
    pb_data[a[6:0]] = d;
    pb_vld[a[6:0]]  = 1'b1;
    pb_last = d;
    t_last = cyc;
  endtask

  task automatic model_commit();
    for (int i = 0; i < 128; i++) begin
      if (pb_vld[i]) ref_mem[{pb_page, 7'(i)}] = pb_data[i];
      pb_vld[i] = 1'b0;
    end
    pb_open = 1'b0;
  endtask

  task automatic model_discard();
    for (int i = 0; i < 128; i++) pb_vld[i] = 1'b0;
    pb_open = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_until(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_idle(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!rb_pull_low) begin ok = 1'b1; break; end
    end
  endtask

  // Poll status in programming, busy near end, release, then model commit.
  task automatic finish_page();
    logic [7:0] d; logic en; bit ok;
    wait_until(t_last + IDLE + 100);
    rd(9'h0, d, en);
    chk(en == 1'b1, "R7 poll enable", int'(en), 1);
    chk(d == {~pb_last[7], pb_last[6:0]}, "R7 poll status", int'(d),
        int'({~pb_last[7], pb_last[6:0]}));
    wait_until(t_last + IDLE + WRT - 40);
    chk(rb_pull_low == 1'b1, "R6 busy held", int'(rb_pull_low), 1);
    wait_idle(ok);
    chk(ok, "R6 busy released", int'(rb_pull_low), 0);
    model_commit();
  endtask

  task automatic check_addr(input logic [8:0] a, input string req);
    logic [7:0] d; logic en;
    rd(a, d, en);
    chk(en && d == ref_mem[a], req, int'(d), int'(ref_mem[a]));
  endtask

  task automatic verify_page(input logic [1:0] p, input string req);
    for (int o = 0; o < 128; o++) check_addr({p, 7'(o)}, req);
  endtask

  initial begin
    logic [7:0] d; logic en;
    logic [8:0] a0;
    void'($urandom(32'h5EED_0A17));
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; res_n = 1'b1;
    addr = '0; din = '0;
    pb_open = 1'b0; pb_page = '0; pb_last = '0; t_last = 0;
    for (int i = 0; i < 128; i++) pb_vld[i] = 1'b0;
    repeat (5) @(negedge clk);
    chk(rb_pull_low == 1'b0, "R6 reset busy", int'(rb_pull_low), 0);
    chk(dout_en == 1'b0, "R10 reset dout_en", int'(dout_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Fill all pages fully (R5 baseline).
    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 128; o++) wr_byte({2'(p), 7'(o)}, 8'($urandom), 6);
      finish_page();
    end
    for (int p = 0; p < 4; p++) verify_page(2'(p), "R5 fill readback");

    // R2: glitch of GLITCH samples ignored.
    pulse(9'h013, ~ref_mem[9'h013], GLITCH);
    repeat (4) @(negedge clk);
    chk(rb_pull_low == 1'b0, "R2 short strobe busy", int'(rb_pull_low), 0);
    check_addr(9'h013, "R2 short strobe data");

    // R1: address from first sample, data from last sample.
    @(negedge clk);
    addr = 9'h0A5; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = 9'h0A6;
    repeat (3) @(negedge clk); din = 8'h5C;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rb_pull_low == 1'b1, "R6 busy after accept", int'(rb_pull_low), 1);
    pb_open = 1'b1; pb_page = 2'd1; pb_data[7'h25] = 8'h5C; pb_vld[7'h25] = 1'b1;
    pb_last = 8'h5C; t_last = cyc;
    finish_page();
    check_addr(9'h0A5, "R1 address first sample");
    check_addr(9'h0A6, "R1 later address untouched");

    // R4: late byte ignored.
    wr_byte(9'h140, 8'h3D, 7);
    repeat (LWIN + 60) @(negedge clk);
    pulse(9'h141, ~ref_mem[9'h141], 8);
    finish_page();
    check_addr(9'h140, "R4 in-window byte");
    check_addr(9'h141, "R4 late byte ignored");

    // R9: strobe during programming ignored.
    wr_byte(9'h1F0, 8'hA7, 6);
    wait_until(t_last + IDLE + 300);
    pulse(9'h1F1, ~ref_mem[9'h1F1], 8);
    finish_page();
    check_addr(9'h1F1, "R9 strobe in programming");
    check_addr(9'h1F0, "R9 page byte");

    // R8: protect low during programming aborts.
    wr_byte(9'h022, ~ref_mem[9'h022], 6);
    wait_until(t_last + IDLE + 50);
    res_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(rb_pull_low == 1'b0, "R8 abort releases busy", int'(rb_pull_low), 0);
    rd(9'h022, d, en);
    chk(en == 1'b0, "R8 read blocked", int'(en), 0);
    pulse(9'h023, ~ref_mem[9'h023], 8);
    repeat (2) @(negedge clk);
    chk(rb_pull_low == 1'b0, "R8 strobe blocked", int'(rb_pull_low), 0);
    res_n = 1'b1;
    model_discard();
    repeat (4) @(negedge clk);
    check_addr(9'h022, "R8 aborted byte");
    check_addr(9'h023, "R8 blocked byte");

    // R8: protect low during loading discards.
    wr_byte(9'h030, ~ref_mem[9'h030], 6);
    repeat (20) @(negedge clk);
    res_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(rb_pull_low == 1'b0, "R8 load abort busy", int'(rb_pull_low), 0);
    res_n = 1'b1;
    model_discard();
    repeat (IDLE + WRT + 20) @(negedge clk);
    check_addr(9'h030, "R8 load abort data");

    // R10: deselected read keeps bus undriven.
    @(negedge clk);
    addr = 9'h010; ce_n = 1'b1; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dout_en == 1'b0, "R10 deselect", int'(dout_en), 0);
    oe_n = 1'b1;
    @(negedge clk);

    // Random pages: R3 page from first byte, R5 partial writes.
    for (int it = 0; it < 6; it++) begin
      int n;
      n = 1 + int'($urandom % 24);
      a0 = 9'($urandom);
      wr_byte(a0, 8'($urandom), 6 + int'($urandom % 4));
      for (int k = 1; k < n; k++) begin
        repeat (int'($urandom % 6)) @(negedge clk);
        wr_byte(9'($urandom), 8'($urandom), 6 + int'($urandom % 4));
      end
      if (it == 0) begin
        wr_byte(a0, 8'h96, 6);  // same offset twice: later wins (R3)
      end
      finish_page();
      verify_page(a0[8:7], "R3 R5 random page");
      check_addr({a0[8:7] + 2'd1, a0[6:0]}, "R3 other page untouched");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule